// File: doc/BRIEF.md
# Fractional Time-Slot HDLC Bit Mapper

This block places transmit HDLC channel bits into several serial links, each divided into frames of time slots with eight bits per slot. Up to 64 logical channels are configured. Each channel is bound to one link and one slot. A mask lists the bit positions of that slot that the channel owns, and a frame-select field limits the channel to even frames, odd frames, both, or neither. A channel can therefore use as little as one bit per frame, or parts of a slot in alternate frames, instead of whole slots.

Position beats arrive one per cycle. Each beat carries the link number, the frame parity and the slot and bit counters of that link. For every beat the block finds the channel that owns the position and sends a one-cycle request to that channel's bit source. It drives the returned bit on the output one cycle later. If no channel owns the position, the output is an idle 1. Configuration is written through two 16-bit words per channel. The new settings are held in a pending copy until the next frame start of the channel's link, so a frame never mixes old and new settings.

Top module: `frac_slot_mapper`

## Requirements
- R1: After reset every channel is inactive (frame select 00). `src_req` is all zero, `out_valid` and `conflict` are 0 and `out_bit` is 1. With no configuration written, every beat produces an idle 1.
- R2: A valid beat is owned by a channel when all of the following hold: its active link equals `pos_link`, its slot equals `pos_slot`, and its mask bit (7 − `pos_bit`) is 1. Mask bit 7 is bit position 0, which is the first bit sent in the slot. Frame select is defined in R3.
- R3: Frame select encoding: 00 gives no frames, 01 gives even frames only (`pos_odd`=0), 10 gives odd frames only (`pos_odd`=1), 11 gives all frames.
- R4: When several channels own the same beat, the lowest-numbered channel is served.
- R5: `conflict` goes to 1 in the cycle after a beat owned by more than one channel, and stays at 1 until reset.
- R6: A beat that no channel owns raises no request and produces `out_bit` = 1.
- R7: For an owned beat presented in cycle t, `src_req` has exactly the owner's bit set in cycle t+1 and no other bit. `out_bit` in cycle t+2 equals the owner's `src_bit` sampled in cycle t+1.
- R8: `out_valid` in cycle t+2 equals `pos_valid` in cycle t. When it is 1, `out_link` equals that beat's `pos_link`.
- R9: `cfg_word`=0 writes the mask from `cfg_wdata[15:8]` and the slot from `cfg_wdata[4:0]`. `cfg_word`=1 writes the link from `cfg_wdata[12:8]` and the frame select from `cfg_wdata[1:0]`. Written values take effect on the first later valid beat with slot 0 and bit 0 on the link the channel is currently bound to. That beat already uses the new values.
- R10: A beat with `pos_valid` = 0 raises no request, applies no pending configuration and cannot set `conflict`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 6 | Channel addressed by the write |
| cfg_word | input | 1 | 0: mask/slot word, 1: link/frame-select word |
| cfg_wdata | input | 16 | Write data |
| pos_valid | input | 1 | Position beat present |
| pos_link | input | 5 | Link of the beat |
| pos_odd | input | 1 | Frame parity of the beat (1 = odd) |
| pos_slot | input | 5 | Slot counter of the beat |
| pos_bit | input | 3 | Bit position within the slot, 0 sent first |
| src_req | output | 64 | One-hot bit request to the channel sources |
| src_bit | input | 64 | Next bit of each channel source |
| out_valid | output | 1 | Output bit present |
| out_link | output | 5 | Link the output bit belongs to |
| out_bit | output | 1 | Mapped bit, 1 when idle |
| conflict | output | 1 | Sticky multiple-owner flag |

## Verification
A stale active or pending configuration shows up at the ports within one frame of the affected link. It appears either as a request to the wrong channel one cycle after the beat, or as a data bit where an idle 1 was expected two cycles after the beat. A wrong priority order or a pending copy applied too early shows up on the first affected beat. The bench runs a model of the pending/active pair and the frame boundary, and compares every beat's request, bit, link and conflict flag. An error in ownership or sequencing therefore appears in the cycle it first occurs, not only at the end of the run.

// File: rtl/frac_slot_mapper_pkg.sv
package frac_slot_mapper_pkg;

    localparam int SLOT_W = 5;
    localparam int LINK_W = 5;
    localparam int MASK_W = 8;
    localparam int BIT_W  = $clog2(MASK_W);
    localparam int WORD_W = 16;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(MASK_W - 1);

    typedef enum logic [1:0] {
        FSEL_NONE = 2'b00,
        FSEL_EVEN = 2'b01,
        FSEL_ODD  = 2'b10,
        FSEL_ALL  = 2'b11
    } fsel_e;

    typedef struct packed {
        logic [LINK_W-1:0] link;
        fsel_e             fsel;
        logic [SLOT_W-1:0] slot;
        logic [MASK_W-1:0] mask;
    } chan_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [LINK_W-1:0] link;
        logic              odd;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitpos;
    } beat_t;

    localparam chan_cfg_t CFG_RESET = '{link: '0, fsel: FSEL_NONE, slot: '0, mask: '0};

    function automatic logic parity_ok(fsel_e f, logic odd);
        case (f)
            FSEL_NONE: return 1'b0;
            FSEL_EVEN: return !odd;
            FSEL_ODD:  return odd;
            default:   return 1'b1;
        endcase
    endfunction

    function automatic logic owns(chan_cfg_t c, beat_t b);
        return b.valid && (c.link == b.link) && (c.slot == b.slot)
            && c.mask[LAST_BIT - b.bitpos] && parity_ok(c.fsel, b.odd);
    endfunction

    function automatic logic frame_start(beat_t b);
        return b.valid && (b.slot == '0) && (b.bitpos == '0);
    endfunction

    // word 0: mask [15:8], slot [4:0]; word 1: link [12:8], frame select [1:0]
    function automatic chan_cfg_t write_cfg(chan_cfg_t c, logic word, logic [WORD_W-1:0] wd);
        chan_cfg_t r;
        r = c;
        if (!word) begin
            r.mask = wd[15:8];
            r.slot = wd[SLOT_W-1:0];
        end else begin
            r.link = wd[8 +: LINK_W];
            r.fsel = fsel_e'(wd[1:0]);
        end
        return r;
    endfunction

endpackage

// File: rtl/frac_slot_cfg_store.sv
module frac_slot_cfg_store
    import frac_slot_mapper_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [CH_W-1:0]          cfg_ch,
    input  logic                     cfg_word,
    input  logic [WORD_W-1:0]        cfg_wdata,
    input  beat_t                    beat,
    output chan_cfg_t [NUM_CH-1:0]   eff_cfg
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        chan_cfg_t act_q;
        chan_cfg_t pend_q;
        logic      dirty_q;
        logic      sel;
        logic      apply;

        assign sel   = cfg_we && (cfg_ch == CH_W'(g));
        // pending copy moves over on the frame start of the currently bound link
        assign apply = dirty_q && frame_start(beat) && (act_q.link == beat.link);
        assign eff_cfg[g] = apply ? pend_q : act_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                act_q   <= CFG_RESET;
                pend_q  <= CFG_RESET;
                dirty_q <= 1'b0;
            end else begin
                act_q <= eff_cfg[g];
                if (sel) begin
                    pend_q  <= write_cfg(pend_q, cfg_word, cfg_wdata);
                    dirty_q <= 1'b1;
                end else if (apply) begin
                    dirty_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/frac_slot_owner_match.sv
module frac_slot_owner_match
    import frac_slot_mapper_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  beat_t                    beat,
    input  chan_cfg_t [NUM_CH-1:0]   cfg,
    output logic                     hit,
    output logic [CH_W-1:0]          owner,
    output logic                     multi
);

    logic [NUM_CH-1:0] claim;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_claim
        assign claim[g] = owns(cfg[g], beat);
    end

    always_comb begin
        owner = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (claim[i]) owner = CH_W'(i);
        end
    end

    assign hit   = |claim;
    assign multi = |(claim & (claim - NUM_CH'(1)));

endmodule

// File: rtl/frac_slot_mapper.sv
module frac_slot_mapper
    import frac_slot_mapper_pkg::*;
#(
    parameter int NUM_CH = 64,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CH_W-1:0]      cfg_ch,
    input  logic                 cfg_word,
    input  logic [WORD_W-1:0]    cfg_wdata,
    input  logic                 pos_valid,
    input  logic [LINK_W-1:0]    pos_link,
    input  logic                 pos_odd,
    input  logic [SLOT_W-1:0]    pos_slot,
    input  logic [BIT_W-1:0]     pos_bit,
    output logic [NUM_CH-1:0]    src_req,
    input  logic [NUM_CH-1:0]    src_bit,
    output logic                 out_valid,
    output logic [LINK_W-1:0]    out_link,
    output logic                 out_bit,
    output logic                 conflict
);

    beat_t                  beat;
    chan_cfg_t [NUM_CH-1:0] eff_cfg;
    logic                   m_hit;
    logic [CH_W-1:0]        m_owner;
    logic                   m_multi;

    logic                   s1_valid;
    logic [LINK_W-1:0]      s1_link;
    logic                   s1_hit;
    logic [CH_W-1:0]        s1_owner;

    assign beat = '{valid: pos_valid, link: pos_link, odd: pos_odd,
                    slot: pos_slot, bitpos: pos_bit};

    frac_slot_cfg_store #(.NUM_CH(NUM_CH), .CH_W(CH_W)) cfg_store_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_word  (cfg_word),
        .cfg_wdata (cfg_wdata),
        .beat      (beat),
        .eff_cfg   (eff_cfg)
    );

    frac_slot_owner_match #(.NUM_CH(NUM_CH), .CH_W(CH_W)) match_i (
        .beat  (beat),
        .cfg   (eff_cfg),
        .hit   (m_hit),
        .owner (m_owner),
        .multi (m_multi)
    );

    // stage 1: request to the owning source
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_link  <= '0;
            s1_hit   <= 1'b0;
            s1_owner <= '0;
            conflict <= 1'b0;
        end else begin
            s1_valid <= pos_valid;
            s1_link  <= pos_link;
            s1_hit   <= m_hit;
            s1_owner <= m_owner;
            if (m_multi) conflict <= 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_req
        assign src_req[g] = s1_hit && (s1_owner == CH_W'(g));
    end

    // stage 2: returned bit, idle ones elsewhere
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_link  <= '0;
            out_bit   <= 1'b1;
        end else begin
            out_valid <= s1_valid;
            out_link  <= s1_link;
            out_bit   <= s1_hit ? src_bit[s1_owner] : 1'b1;
        end
    end

endmodule

module frac_slot_mapper_chk #(
    parameter int NUM_CH = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              pos_valid,
    input logic [NUM_CH-1:0] src_req,
    input logic [NUM_CH-1:0] src_bit,
    input logic              out_bit,
    input logic              out_valid,
    input logic              conflict
);

    assert_req_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_req));

    assert_req_data_R7: assert property (@(posedge clk) disable iff (rst)
        (|src_req) |=> (out_bit == $past(|(src_req & src_bit))));

    assert_req_needs_beat_R10: assert property (@(posedge clk) disable iff (rst)
        (|src_req) |-> $past(pos_valid));

    assert_idle_one_R6: assert property (@(posedge clk) disable iff (rst)
        !(|src_req) |=> out_bit);

    assert_conflict_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        conflict |=> conflict);

    assert_conflict_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(conflict) |-> $past(pos_valid));

    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (rst)
        pos_valid |-> ##2 out_valid);

endmodule

bind frac_slot_mapper frac_slot_mapper_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .pos_valid (pos_valid),
    .src_req   (src_req),
    .src_bit   (src_bit),
    .out_bit   (out_bit),
    .out_valid (out_valid),
    .conflict  (conflict)
);

// File: tb/frac_slot_mapper_tb.sv
module frac_slot_mapper_tb_top;

    localparam int NCH   = 64;
    localparam int NLINK = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_ch = '0;
    logic        cfg_word = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        pos_valid = 1'b0;
    logic [4:0]  pos_link = '0;
    logic        pos_odd = 1'b0;
    logic [4:0]  pos_slot = '0;
    logic [2:0]  pos_bit = '0;
    logic [63:0] src_req;
    logic [63:0] src_bit;
    logic        out_valid;
    logic [4:0]  out_link;
    logic        out_bit;
    logic        conflict;

    always #4 clk = ~clk;

    frac_slot_mapper dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_word(cfg_word),
        .cfg_wdata(cfg_wdata), .pos_valid(pos_valid), .pos_link(pos_link), .pos_odd(pos_odd),
        .pos_slot(pos_slot), .pos_bit(pos_bit), .src_req(src_req), .src_bit(src_bit),
        .out_valid(out_valid), .out_link(out_link), .out_bit(out_bit), .conflict(conflict)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // channel bit sources
    int src_cnt [NCH];

    function automatic logic seq_bit(int c, int n);
        int x;
        x = c * 131 + n * 29;
        return logic'(((x) ^ (x >> 3) ^ (x >> 5)) & 1);
    endfunction

    always_comb begin
        for (int c = 0; c < NCH; c++) src_bit[c] = seq_bit(c, src_cnt[c]);
    end

    always_ff @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst) src_cnt[c] <= 0;
            else if (src_req[c]) src_cnt[c] <= src_cnt[c] + 1;
        end
    end

    // reference model
    int a_link [NCH], a_fsel [NCH], a_slot [NCH], a_mask [NCH];
    int q_link [NCH], q_fsel [NCH], q_slot [NCH], q_mask [NCH];
    bit q_dirty [NCH];
    int mcnt [NCH];
    bit m_conf = 1'b0;
    int lk_slot [NLINK], lk_bit [NLINK];
    bit lk_odd [NLINK];

    bit    p1_v = 0, p1_hit = 0, p1_bit = 1, p1_conf = 0;
    int    p1_link = 0, p1_owner = 0;
    string p1_tag = "R1";
    bit    p2_v = 0, p2_bit = 1;
    int    p2_link = 0;
    string p2_tag = "R1";

    task automatic chk(bit ok, string what, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit model_owns(int c, int l, bit odd, int slot, int bp);
        bit par;
        case (a_fsel[c])
            0: par = 0;
            1: par = !odd;
            2: par = odd;
            default: par = 1;
        endcase
        return par && a_link[c] == l && a_slot[c] == slot && (((a_mask[c] >> (7 - bp)) & 1) == 1);
    endfunction

    task automatic step(bit v, int l, bit odd, int slot, int bp,
                        bit we, int ch, bit word, logic [15:0] wd, string tag);
        logic [63:0] exp_req;
        int cnt;
        int own;
        @(negedge clk);
        // beat n-2 at the output, beat n-1 at the request
        chk(out_valid == p2_v, "out_valid", "R8", out_valid, p2_v);
        if (p2_v) chk(out_link == 5'(p2_link), "out_link", "R8", out_link, p2_link);
        chk(out_bit == p2_bit, "out_bit", p2_tag, out_bit, p2_bit);
        exp_req = p1_hit ? (64'd1 << p1_owner) : 64'd0;
        chk(src_req == exp_req, "src_req", {"R7/", p1_tag}, src_req, exp_req);
        chk(conflict == p1_conf, "conflict", "R5", conflict, p1_conf);
        p2_v = p1_v; p2_bit = p1_bit; p2_link = p1_link; p2_tag = p1_tag;
        // drive
        pos_valid = v; pos_link = 5'(l); pos_odd = odd; pos_slot = 5'(slot); pos_bit = 3'(bp);
        cfg_we = we; cfg_ch = 6'(ch); cfg_word = word; cfg_wdata = wd;
        // model of this beat
        if (v && slot == 0 && bp == 0) begin
            for (int c = 0; c < NCH; c++) begin
                if (q_dirty[c] && a_link[c] == l) begin
                    a_link[c] = q_link[c]; a_fsel[c] = q_fsel[c];
                    a_slot[c] = q_slot[c]; a_mask[c] = q_mask[c];
                    q_dirty[c] = 0;
                end
            end
        end
        cnt = 0; own = 0;
        if (v) begin
            for (int c = NCH - 1; c >= 0; c--) begin
                if (model_owns(c, l, odd, slot, bp)) begin
                    cnt++; own = c;
                end
            end
        end
        if (cnt > 1) m_conf = 1;
        p1_v = v; p1_link = l; p1_hit = (cnt > 0); p1_owner = own; p1_conf = m_conf;
        if (cnt > 0) begin
            p1_bit = seq_bit(own, mcnt[own]);
            mcnt[own]++;
        end else begin
            p1_bit = 1;
        end
        p1_tag = $sformatf("%s/%s", tag, (cnt == 0) ? "R6" : (cnt > 1) ? "R4" : "R2");
        if (we) begin
            if (!word) begin
                q_mask[ch] = int'(wd[15:8]); q_slot[ch] = int'(wd[4:0]);
            end else begin
                q_link[ch] = int'(wd[12:8]); q_fsel[ch] = int'(wd[1:0]);
            end
            q_dirty[ch] = 1;
        end
    endtask

    task automatic beat_on(int l, string tag);
        step(1, l, lk_odd[l], lk_slot[l], lk_bit[l], 0, 0, 0, 16'h0, tag);
        lk_bit[l]++;
        if (lk_bit[l] == 8) begin
            lk_bit[l] = 0;
            lk_slot[l]++;
            if (lk_slot[l] == 32) begin
                lk_slot[l] = 0;
                lk_odd[l] = !lk_odd[l];
            end
        end
    endtask

    task automatic idle(string tag);
        step(0, $urandom % 32, 1'($urandom), $urandom % 32, $urandom % 8, 0, 0, 0, 16'h0, tag);
    endtask

    task automatic wr(int ch, bit word, logic [15:0] wd, string tag);
        step(0, $urandom % 32, 1'($urandom), $urandom % 32, $urandom % 8, 1, ch, word, wd, tag);
    endtask

    // shape word: mask in [15:8], slot in [4:0]; bind word: link in [12:8], frame select in [1:0]
    function automatic logic [15:0] shape_w(int mask, int slot);
        return {8'(mask), 3'b000, 5'(slot)};
    endfunction

    function automatic logic [15:0] bind_w(int link, int fsel);
        return {3'b000, 5'(link), 6'b000000, 2'(fsel)};
    endfunction

    initial begin
        for (int c = 0; c < NCH; c++) begin
            a_link[c] = 0; a_fsel[c] = 0; a_slot[c] = 0; a_mask[c] = 0;
            q_link[c] = 0; q_fsel[c] = 0; q_slot[c] = 0; q_mask[c] = 0;
            q_dirty[c] = 0; mcnt[c] = 0;
        end
        for (int l = 0; l < NLINK; l++) begin
            lk_slot[l] = 0; lk_bit[l] = 0; lk_odd[l] = 0;
        end
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(src_req == 64'd0, "src_req after reset", "R1", src_req, 0);
        chk(out_valid == 1'b0, "out_valid after reset", "R1", out_valid, 0);
        chk(conflict == 1'b0, "conflict after reset", "R1", conflict, 0);
        chk(out_bit == 1'b1, "out_bit after reset", "R1", out_bit, 1);

        // R1: unconfigured channels never take a beat
        for (int i = 0; i < 260; i++) beat_on(0, "R1");

        // R9: pending settings wait for the frame start of the bound link
        for (int i = 0; i < 20; i++) beat_on(1, "R9");
        wr(5, 0, shape_w(8'hFF, 3), "R9");
        wr(5, 1, bind_w(1, 3), "R9");
        for (int i = 0; i < 248; i++) beat_on(1, "R9");
        wr(5, 0, shape_w(8'h81, 2), "R9");
        for (int i = 0; i < 300; i++) beat_on(1, "R9");

        // R3: frame parity selection
        wr(8, 0, shape_w(8'h0F, 4), "R3");  wr(8, 1, bind_w(2, 1), "R3");
        wr(9, 0, shape_w(8'hF0, 4), "R3");  wr(9, 1, bind_w(2, 2), "R3");
        wr(10, 0, shape_w(8'h3C, 5), "R3"); wr(10, 1, bind_w(2, 0), "R3");
        for (int i = 0; i < 3 * 256 + 10; i++) beat_on(2, "R3");

        // R4 and R5: overlapping owners
        wr(12, 0, shape_w(8'hFF, 6), "R4"); wr(12, 1, bind_w(3, 3), "R4");
        wr(20, 0, shape_w(8'hFF, 6), "R4"); wr(20, 1, bind_w(3, 3), "R4");
        wr(3, 0, shape_w(8'h01, 6), "R4");  wr(3, 1, bind_w(3, 1), "R4");
        for (int i = 0; i < 2 * 256 + 10; i++) beat_on(3, "R4");

        // random mix, with invalid beats for R10
        for (int i = 0; i < 12000; i++) begin
            int r;
            r = $urandom % 16;
            if (r == 0) begin
                idle("R10");
            end else if (r == 1) begin
                int ch;
                bit word;
                logic [15:0] wd;
                ch = $urandom % NCH;
                word = 1'($urandom);
                wd = 16'($urandom);
                if (!word) wd[4:0] = 5'($urandom % 8);
                else wd[12:8] = 5'($urandom % NLINK);
                wr(ch, word, wd, "R9");
            end else begin
                beat_on($urandom % NLINK, "R2");
            end
        end
        for (int i = 0; i < 3; i++) idle("R10");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule